// File: doc/BRIEF.md
# MSB-First Variable-Length Bit Unpacker

The unpacker turns a stream of 16-bit words back into the variable-length fields a matching packer wrote into it. Words arrive on a valid/ready input port. Fields are pulled out by a request that carries a length from 1 to 16. Each accepted request produces the next bits of the stream, read most significant bit first. The result comes back one cycle later with a single-cycle valid strobe.

A 32-bit holding window made of an upper and a lower half sits between the two sides. A read pointer marks the next unread bit in the upper half. When the pointer has moved past the whole upper word, the window moves up by one word: the lower half replaces the upper half and the pointer drops by 16. New words are only ever written into the lower half. Startup uses the same path. The first word lands in the lower half and is moved up, and the second word then fills the lower half. This costs one extra cycle before the first field can be served. Giving meaning to the fields, for example as truncated binary codes, is left to the logic downstream.

Top module: `bit_unpacker`

## Requirements
- R1: While reset is asserted and just after it is released, `in_ready` is 1, `req_ready` is 0 and `fld_valid` is 0.
- R2: No field request is accepted until two input words have been accepted since reset.
- R3: Legal request lengths are 1 to 16. Each accepted request of length L returns the next L unread bits of the stream, taking bit 15 of each word first and words in the order they were accepted.
- R4: A returned field is right-aligned in `fld_data`: the last stream bit of the field is bit 0, and bits L and above are 0.
- R5: `fld_valid` is high for exactly one cycle, in the cycle after each accepted request, and is low at all other times.
- R6: A request is held off (`req_ready` low) while the window holds fewer unread bits than the requested length. It is served, with no bit lost or repeated, once enough words have arrived.
- R7: A word waiting in the lower half is never overwritten: `in_ready` stays low until that word has moved to the upper half.
- R8: When the upper word is fully consumed and the lower half holds a word, the window moves up on the next clock edge. After that move, fewer than 16 bits of the new upper word are consumed.
- R9: A field of length 16 whose bits span both halves of the window is returned correctly.
- R10: A reset in the middle of a stream throws away all buffered bits. The unpacker returns to the priming state, and the next field starts at bit 15 of the first word accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 16 | Incoming stream word |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Unpacker can take a word this cycle |
| req_valid | input | 1 | Field request present |
| req_len | input | 5 | Requested field length, 1 to 16 |
| req_ready | output | 1 | Request accepted this cycle if `req_valid` is high |
| fld_data | output | 16 | Right-aligned field value |
| fld_valid | output | 1 | `fld_data` holds a new field |

## Verification
The hardest state to reach is a stall where part of a word is still unread, the lower half is empty, and the pending request asks for more bits than remain. When words arrive freely, the lower half is refilled almost at once, so this state never lasts. The stimulus creates it on purpose. It caps how many words the feeder may hand over, then issues requests whose lengths add up to leave exactly 12 bits, and then asks for 13. The bench holds the stall for several cycles and checks it before it lifts the cap. The same cap technique lets the bench watch priming with only one word supplied, and watch the input stall with a full window and no requests.

// File: rtl/bu_pkg.sv
package bu_pkg;

  typedef enum logic {
    ST_PRIME = 1'b0,
    ST_RUN   = 1'b1
  } bu_state_e;

endpackage

// File: rtl/bu_store.sv
module bu_store #(
  parameter int W  = 16,
  parameter int DW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [W-1:0]  in_data,
  output logic [DW-1:0] win,
  output logic          lo_full
);

  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic         lo_full_q;
  logic         lo_full_d;

  always_comb begin
    lo_full_d = lo_full_q;
    if (load) begin
      lo_full_d = 1'b1;
    end else if (adv) begin
      lo_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_full_q <= 1'b0;
    end else if (load || adv) begin
      lo_full_q <= lo_full_d;
    end
  end

  // data halves carry no reset; validity is tracked by lo_full_q and the pointer
  always_ff @(posedge clk) begin
    if (adv) begin
      hi_q <= lo_q;
    end
    if (load) begin
      lo_q <= in_data;
    end
  end

  assign win     = {hi_q, lo_q};
  assign lo_full = lo_full_q;

endmodule

// File: rtl/bu_ctrl.sv
module bu_ctrl
  import bu_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = $clog2(2 * W),
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          req_valid,
  input  logic [LW-1:0] req_len,
  input  logic          lo_full,
  output logic          in_ready,
  output logic          req_ready,
  output logic          load,
  output logic          adv,
  output logic          take,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] PTR_WORD = PW'(W);
  localparam logic [PW:0]   CAP_ONE  = (PW + 1)'(W);
  localparam logic [PW:0]   CAP_TWO  = (PW + 1)'(2 * W);

  bu_state_e     st_q, st_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          top_spent;
  logic [PW:0]   avail;
  logic          fits;

  always_comb begin
    top_spent = (ptr_q >= PTR_WORD);
    avail     = (lo_full ? CAP_TWO : CAP_ONE) - {1'b0, ptr_q};
    fits      = ((PW + 1)'(req_len) <= avail);
    in_ready  = !lo_full;
    load      = in_valid && !lo_full;
    adv       = top_spent && lo_full;
    req_ready = (st_q == ST_RUN) && !top_spent && fits;
    take      = req_ready && req_valid;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = ptr_q - PTR_WORD;
    end else if (take) begin
      ptr_d = ptr_q + PW'(req_len);
    end
  end

  always_comb begin
    st_d = st_q;
    if ((st_q == ST_PRIME) && load && !top_spent) begin
      st_d = ST_RUN;
    end
  end

  // after reset the upper word counts as fully consumed, so the first word
  // goes through the normal lower-to-upper move
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_WORD;
    end else if (adv || take) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PRIME;
    end else if (st_q != st_d) begin
      st_q <= st_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/bu_extract.sv
module bu_extract #(
  parameter int W  = 16,
  parameter int DW = 2 * W,
  parameter int PW = $clog2(DW),
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] win,
  input  logic [PW-1:0] ptr,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  fld_data,
  output logic          fld_valid
);

  logic [DW-1:0] aligned;
  logic [W-1:0]  top_bits;
  logic [LW-1:0] rsh;
  logic [W-1:0]  fld_d;
  logic [W-1:0]  fld_q;
  logic          vld_q;

  always_comb begin
    aligned  = win << ptr;
    top_bits = aligned[DW-1 -: W];
    rsh      = LW'(W) - len;
    fld_d    = top_bits >> rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (take) begin
      fld_q <= fld_d;
    end
  end

  assign fld_data  = fld_q;
  assign fld_valid = vld_q;

endmodule

// File: rtl/bit_unpacker.sv
module bit_unpacker #(
  parameter int WORD_W = 16,
  localparam int DW    = 2 * WORD_W,
  localparam int PW    = $clog2(DW),
  localparam int LW    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              req_valid,
  input  logic [LW-1:0]     req_len,
  output logic              req_ready,
  output logic [WORD_W-1:0] fld_data,
  output logic              fld_valid
);

  logic          load;
  logic          adv;
  logic          take;
  logic          lo_full;
  logic [PW-1:0] ptr;
  logic [DW-1:0] win;

  bu_ctrl #(.W(WORD_W), .PW(PW), .LW(LW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .req_valid (req_valid),
    .req_len   (req_len),
    .lo_full   (lo_full),
    .in_ready  (in_ready),
    .req_ready (req_ready),
    .load      (load),
    .adv       (adv),
    .take      (take),
    .ptr       (ptr)
  );

  bu_store #(.W(WORD_W), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .in_data (in_data),
    .win     (win),
    .lo_full (lo_full)
  );

  bu_extract #(.W(WORD_W), .DW(DW), .PW(PW), .LW(LW)) u_extract (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .win       (win),
    .ptr       (ptr),
    .len       (req_len),
    .fld_data  (fld_data),
    .fld_valid (fld_valid)
  );

endmodule

// File: rtl/bit_unpacker_chk.sv
module bit_unpacker_chk #(
  parameter int W  = 16,
  parameter int PW = $clog2(2 * W),
  parameter int LW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [LW-1:0] req_len,
  input logic          fld_valid,
  input logic          lo_full,
  input logic [PW-1:0] ptr
);

  logic [1:0]  words_seen;
  logic [PW:0] room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_seen <= 2'd0;
    end else if (in_valid && in_ready && (words_seen != 2'd2)) begin
      words_seen <= words_seen + 2'd1;
    end
  end

  always_comb begin
    room = (lo_full ? (PW + 1)'(2 * W) : (PW + 1)'(W)) - {1'b0, ptr};
  end

  p_prime_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (words_seen == 2'd2));

  p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_len != '0) && (req_len <= LW'(W))));

  p_fld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> fld_valid);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !fld_valid);

  p_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((ptr < PW'(W)) && ((PW + 1)'(req_len) <= room)));

  p_lo_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_full && (ptr < PW'(W))) |=> lo_full);

  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_full && (ptr >= PW'(W))) |=> (!lo_full && (ptr < PW'(W))));

endmodule

bind bit_unpacker bit_unpacker_chk #(.W(WORD_W), .PW(PW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_len   (req_len),
  .fld_valid (fld_valid),
  .lo_full   (lo_full),
  .ptr       (ptr)
);

// File: tb/test_bit_unpacker.sv
module test_bit_unpacker;

  localparam int NW = 64;

  typedef struct {
    logic [15:0] v;
    int          len;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] in_data;
  logic        in_valid;
  logic        in_ready;
  logic        req_valid;
  logic [4:0]  req_len;
  logic        req_ready;
  logic [15:0] fld_data;
  logic        fld_valid;

  logic [15:0] words [NW];
  exp_t        q [$];
  int          n_chk;
  int          n_fail;
  int          idx;
  int          feed_limit;
  bit          throttle;
  int          cursor;
  bit          done;

  bit_unpacker #(.WORD_W(16)) i_bit_unpacker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_ready (req_ready),
    .fld_data  (fld_data),
    .fld_valid (fld_valid)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [15:0] exp_bits(input int cur, input int len);
    logic [15:0] v;
    v = '0;
    for (int i = 0; i < len; i++) begin
      v = {v[14:0], words[(cur + i) / 16][15 - ((cur + i) % 16)]};
    end
    return v;
  endfunction

  // driver: queue the expected field, then hold the request until accepted
  task automatic send_req(input int len);
    exp_t e;
    e.v   = exp_bits(cursor, len);
    e.len = len;
    q.push_back(e);
    cursor += len;
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = 5'(len);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // word feeder
  initial begin
    in_valid = 1'b0;
    in_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && (idx < feed_limit) && (!throttle || ($urandom_range(3, 0) != 0))) begin
        in_valid = 1'b1;
        in_data  = words[idx];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && in_ready) begin
        @(posedge clk);
        idx++;
      end
    end
  end

  // monitor: compare every produced field with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && fld_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R5 unexpected field", 32'(fld_data), 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(fld_data == e.v, "R3 field value", 32'(fld_data), 32'(e.v));
        check((32'(fld_data) >> e.len) == 0, "R4 upper bits zero", 32'(fld_data), 32'(e.v));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; idx = 0; feed_limit = 0; throttle = 1'b0;
    cursor = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_len = 5'd1;
    for (int i = 0; i < NW; i++) words[i] = 16'($urandom);

    repeat (3) @(negedge clk);
    #2;
    check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'h1);
    check(req_ready == 1'b0, "R1 req_ready in reset", 32'(req_ready), 32'h0);
    check(fld_valid == 1'b0, "R1 fld_valid in reset", 32'(fld_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(req_ready == 1'b0, "R1 req_ready after release", 32'(req_ready), 32'h0);

    // R2: one word only, request must wait
    feed_limit = 1;
    fork send_req(4); join_none
    repeat (8) @(negedge clk);
    #2;
    check(req_ready == 1'b0, "R2 held with one word", 32'(req_ready), 32'h0);
    check(q.size() == 1, "R2 no field with one word", 32'(q.size()), 32'h1);
    feed_limit = 3;
    while (req_valid) @(negedge clk);
    drain();

    // R9: full-width fields crossing both halves
    send_req(16);
    send_req(16);
    drain();

    // R6: 12 bits left, lower half empty, ask for 13
    repeat (4) @(negedge clk);
    fork send_req(13); join_none
    repeat (6) @(negedge clk);
    #2;
    check(req_ready == 1'b0, "R6 stall on short window", 32'(req_ready), 32'h0);
    check(q.size() == 1, "R6 no field while short", 32'(q.size()), 32'h1);
    feed_limit = 6;
    while (req_valid) @(negedge clk);
    drain();

    // R7/R8: window full, no requests; input must stall
    repeat (10) @(negedge clk);
    #2;
    check(in_ready == 1'b0, "R7 input held when full", 32'(in_ready), 32'h0);
    check(idx == 5, "R7 words accepted", 32'(idx), 32'h5);

    // random lengths and gaps, throttled feed
    feed_limit = NW;
    throttle   = 1'b1;
    while (cursor + 16 <= NW * 16) begin
      send_req($urandom_range(16, 1));
      repeat ($urandom_range(2, 0)) @(negedge clk);
    end
    drain();

    // R10: reset mid-stream
    feed_limit = 0;
    throttle   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n  = 1'b0;
    idx    = 0;
    cursor = 0;
    #2;
    check(in_ready == 1'b1, "R10 in_ready after mid reset", 32'(in_ready), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(req_ready == 1'b0, "R10 priming again", 32'(req_ready), 32'h0);
    feed_limit = 2;
    send_req(7);   // R10: must return the top of words[0]
    drain();
    check(q.size() == 0, "R10 restart field served", 32'(q.size()), 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule